// File: doc/BRIEF.md
# Low Frequency Clock Monitor

This block watches a monitored clock and raises an alarm when that clock runs too slowly. The time base comes from an internal RC clock. A programmable power of two, from 1 to 8 RC cycles, sets the length of each measuring window. A counter running on the monitored clock counts its rising edges. At each window boundary a toggle handshake moves a snapshot of that count into the RC domain. The snapshot is compared there against a programmable lower threshold.

A window whose count is below the threshold is a failure, but only if the monitored clock is marked enabled at the moment the result is decided. A failure sets a sticky status flag, which also drives an interrupt level, and produces a one-cycle failure event for downstream reset and safe-mode logic. If the monitored clock stops completely, the handshake never completes. A timeout in the RC domain then treats that window as a count of zero.

A small register port in the RC domain holds the divider, the threshold and the write-one-to-clear status flag. After reset the threshold is zero, so no failure can occur until software programs a threshold.

Top module: `lfcm_monitor`

## Requirements
- R1: After reset the divider field reads 3, the threshold reads 0, the status flag reads 0, and neither fail_evt nor fail_irq is asserted.
- R2: When a completed window holds fewer monitored-clock edges than the threshold and mon_en is high, the status flag is set, fail_irq goes high, and fail_evt pulses.
- R3: A window whose count is at or above the threshold raises no failure. The edge counter saturates at all ones instead of wrapping, so a very fast clock never looks slow.
- R4: While the threshold is zero, no failure is raised, even if the monitored clock is stopped.
- R5: While mon_en is low, no failure is raised and the status flag is left unchanged.
- R6: If the monitored clock stops, a window that gets no handshake answer within TMO_CYC RC cycles counts as zero edges. That window fails when the threshold is nonzero and mon_en is high. The late answer that follows such a timeout is discarded.
- R7: The status flag (address 2, bit 0) is sticky. Writing 1 to that bit clears it, writing 0 leaves it set, and a new failure in the same cycle as a clearing write wins.
- R8: fail_evt is a single-cycle pulse and is never high in two consecutive RC cycles.
- R9: Each window lasts 2^div RC cycles plus the handshake latency. div is the 2-bit field at address 0, bits [1:0]. It is sampled when a window starts, and bits written above it are dropped.
- R10: Register map: address 0 holds the divider in bits [1:0]; address 1 holds the 12-bit threshold in bits [11:0]; address 2 holds the status flag in bit 0; address 3 reads as zero. Unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rc_clk | input | 1 | RC reference clock; the register port and the comparison logic run on it |
| mon_clk | input | 1 | Monitored clock whose edges are counted |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mon_en | input | 1 | High while the monitored clock is enabled; qualifies failures |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| fail_evt | output | 1 | One-cycle failure event |
| fail_irq | output | 1 | Level copy of the sticky status flag |

## Verification
The embedded assertions cover the cycle-level rules on every cycle. They check that the event never lasts two cycles and only follows a cycle with mon_en high and a nonzero threshold. They check that every event leaves the flag set and that the flag falls only after a clearing write. They also check that a window request is issued only when a window ends, that a window cannot both complete and time out in the same cycle, and that the edge counter holds at saturation. Only the bench's scenarios can show the frequency-dependent outcomes. These include whether a given clock rate passes or fails a given threshold, how the divider stretches the window enough to turn a failure into a pass, and whether a stopped clock is caught by the timeout.

// File: rtl/lfcm_pkg.sv
package lfcm_pkg;

  localparam int unsigned DIV_W = 2;
  localparam int unsigned CNT_W = 12;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_THR  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic {
    WS_RUN  = 1'b0,
    WS_WAIT = 1'b1
  } win_state_e;

  // Window length in RC cycles for a divider code: 2^div.
  function automatic int unsigned window_cycles(input logic [DIV_W-1:0] div);
    return 32'd1 << div;
  endfunction

  // A window fails when its edge count is strictly below the threshold.
  function automatic logic count_low(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] thr);
    return cnt < thr;
  endfunction

  // Saturating increment for the edge counter.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] cnt);
    return (cnt == {CNT_W{1'b1}}) ? cnt : cnt + 1'b1;
  endfunction

endpackage

// File: rtl/lfcm_edge_counter.sv
module lfcm_edge_counter
  import lfcm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             mon_clk,
  input  logic             rst_n,
  input  logic             req_tog,
  output logic [CNT_W-1:0] cap_cnt,
  output logic             ack_tog
);

  localparam int unsigned SR_W = SYNC_STAGES + 1;

  logic [SR_W-1:0]  req_sr;
  logic [CNT_W-1:0] edge_cnt;
  logic             snap;

  // Bring the request toggle into the monitored domain; one extra stage
  // finds its edge.
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) req_sr <= '0;
    else        req_sr <= {req_sr[SR_W-2:0], req_tog};
  end

  assign snap = req_sr[SR_W-1] ^ req_sr[SR_W-2];

  // On a snapshot, freeze the finished window's count and return the toggle.
  // The edge of this cycle is the first edge of the new window.
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      cap_cnt  <= '0;
      ack_tog  <= 1'b0;
    end else if (snap) begin
      cap_cnt  <= edge_cnt;
      edge_cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
      ack_tog  <= req_sr[SR_W-2];
    end else begin
      edge_cnt <= sat_inc(edge_cnt);
    end
  end

  // R3: a full counter stays full or is handed over as full, never wraps
  a_r3_counter_saturates: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (edge_cnt == {CNT_W{1'b1}}) |=> (edge_cnt == {CNT_W{1'b1}} || cap_cnt == {CNT_W{1'b1}}))
    else $error("edge counter wrapped");

endmodule

// File: rtl/lfcm_window_ctrl.sv
module lfcm_window_ctrl
  import lfcm_pkg::*;
#(
  parameter int unsigned TMO_CYC     = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             rc_clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             ack_tog,
  output logic             req_tog,
  output logic             done_pulse,
  output logic             tmo_pulse
);

  localparam int unsigned MAX_WIN = 1 << ((1 << DIV_W) - 1);
  localparam int unsigned TIMER_W = $clog2(MAX_WIN) + 1;
  localparam int unsigned TMO_W   = $clog2(TMO_CYC) + 1;

  win_state_e             state;
  logic [SYNC_STAGES-1:0] ack_sr;
  logic                   ack_seen;
  logic [TIMER_W-1:0]     timer;
  logic [TIMER_W-1:0]     win_q;
  logic [TMO_W-1:0]       tmo_cnt;
  logic                   stale;
  logic                   win_end;
  logic                   answered;
  logic                   tmo_hit;

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) ack_sr <= '0;
    else        ack_sr <= {ack_sr[SYNC_STAGES-2:0], ack_tog};
  end

  assign ack_seen = ack_sr[SYNC_STAGES-1];
  assign win_end  = (state == WS_RUN) && (timer == win_q - 1'b1);
  assign answered = (state == WS_WAIT) && (ack_seen == req_tog);
  assign tmo_hit  = (state == WS_WAIT) && !answered &&
                    (tmo_cnt == TMO_W'(TMO_CYC - 1));

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= WS_RUN;
      timer      <= '0;
      win_q      <= TIMER_W'(MAX_WIN);
      tmo_cnt    <= '0;
      stale      <= 1'b0;
      req_tog    <= 1'b0;
      done_pulse <= 1'b0;
      tmo_pulse  <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      tmo_pulse  <= 1'b0;
      unique case (state)
        WS_RUN: begin
          if (win_end) begin
            req_tog <= ~req_tog;
            timer   <= '0;
            tmo_cnt <= '0;
            state   <= WS_WAIT;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        WS_WAIT: begin
          if (answered) begin
            done_pulse <= !stale;
            stale      <= 1'b0;
            win_q      <= TIMER_W'(window_cycles(div));
            timer      <= '0;
            state      <= WS_RUN;
          end else if (tmo_hit) begin
            tmo_pulse <= 1'b1;
            stale     <= 1'b1;
            tmo_cnt   <= '0;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        default: state <= WS_RUN;
      endcase
    end
  end

  // R8: a window either completes or times out, never both in one cycle
  a_r8_done_tmo_exclusive: assert property (@(posedge rc_clk) disable iff (!rst_n)
    $onehot0({done_pulse, tmo_pulse}))
    else $error("done and timeout together");

  // R9: a new request goes out only when a running window ends
  a_r9_req_at_window_end: assert property (@(posedge rc_clk) disable iff (!rst_n)
    (req_tog != $past(req_tog)) |-> ($past(state) == WS_RUN && state == WS_WAIT))
    else $error("request outside window end");

  // R6: a timeout happens only while an answer is outstanding
  a_r6_tmo_while_waiting: assert property (@(posedge rc_clk) disable iff (!rst_n)
    tmo_pulse |-> (state == WS_WAIT && stale))
    else $error("timeout outside wait");

endmodule

// File: rtl/lfcm_regs.sv
module lfcm_regs
  import lfcm_pkg::*;
#(
  parameter int unsigned     DATA_W  = 32,
  parameter logic [DIV_W-1:0] DIV_RST = 2'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_flag,
  output logic [DIV_W-1:0]  div,
  output logic [CNT_W-1:0]  thr,
  output logic              flag,
  output logic [DATA_W-1:0] rdata
);

  reg_addr_e sel;
  logic      clr_flag;
  logic      unused_wdata;

  assign sel          = reg_addr_e'(addr);
  assign clr_flag     = we && (sel == ADDR_STAT) && wdata[0];
  assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= DIV_RST;
      thr <= '0;
    end else if (we) begin
      if (sel == ADDR_CTRL) div <= wdata[DIV_W-1:0];
      if (sel == ADDR_THR)  thr <= wdata[CNT_W-1:0];
    end
  end

  // A new failure takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set_flag) flag <= 1'b1;
    else if (clr_flag) flag <= 1'b0;
  end

  always_comb begin
    unique case (sel)
      ADDR_CTRL: rdata = DATA_W'(div);
      ADDR_THR:  rdata = DATA_W'(thr);
      ADDR_STAT: rdata = DATA_W'(flag);
      default:   rdata = '0;
    endcase
  end

  // R7: the flag falls only after a write of one to the status bit
  a_r7_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(we && addr == ADDR_STAT && wdata[0]))
    else $error("flag cleared without write");

  // R7: a set request always leaves the flag high
  a_r7_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_flag) |-> flag)
    else $error("flag not set after failure");

endmodule

// File: rtl/lfcm_monitor.sv
module lfcm_monitor
  import lfcm_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TMO_CYC     = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              rc_clk,
  input  logic              mon_clk,
  input  logic              rst_n,
  input  logic              mon_en,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              fail_evt,
  output logic              fail_irq
);

  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] cap_cnt;
  logic             req_tog;
  logic             ack_tog;
  logic             done_pulse;
  logic             tmo_pulse;
  logic             window_fail;
  logic             timeout_fail;
  logic             flag;

  lfcm_regs #(.DATA_W(DATA_W), .DIV_RST(2'd3)) u_regs (
    .clk      (rc_clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .set_flag (fail_evt),
    .div      (div),
    .thr      (thr),
    .flag     (flag),
    .rdata    (reg_rdata)
  );

  lfcm_window_ctrl #(.TMO_CYC(TMO_CYC), .SYNC_STAGES(SYNC_STAGES)) u_win (
    .rc_clk     (rc_clk),
    .rst_n      (rst_n),
    .div        (div),
    .ack_tog    (ack_tog),
    .req_tog    (req_tog),
    .done_pulse (done_pulse),
    .tmo_pulse  (tmo_pulse)
  );

  lfcm_edge_counter #(.SYNC_STAGES(SYNC_STAGES)) u_cnt (
    .mon_clk (mon_clk),
    .rst_n   (rst_n),
    .req_tog (req_tog),
    .cap_cnt (cap_cnt),
    .ack_tog (ack_tog)
  );

  // cap_cnt has been stable for at least the ack synchroniser depth here.
  assign window_fail  = done_pulse && count_low(cap_cnt, thr);
  assign timeout_fail = tmo_pulse && count_low('0, thr);

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) fail_evt <= 1'b0;
    else        fail_evt <= mon_en && (window_fail || timeout_fail);
  end

  assign fail_irq = flag;

  // R8: the failure event lasts one cycle
  a_r8_single_cycle_event: assert property (@(posedge rc_clk) disable iff (!rst_n)
    fail_evt |=> !fail_evt)
    else $error("event longer than one cycle");

  // R5: no event unless the monitored clock was enabled
  a_r5_event_needs_enable: assert property (@(posedge rc_clk) disable iff (!rst_n)
    fail_evt |-> $past(mon_en))
    else $error("event while disabled");

  // R4: a zero threshold never produces an event
  a_r4_zero_threshold_quiet: assert property (@(posedge rc_clk) disable iff (!rst_n)
    fail_evt |-> ($past(thr) != '0))
    else $error("event with zero threshold");

  // R5: the flag does not rise while disabled
  a_r5_flag_quiet_disabled: assert property (@(posedge rc_clk) disable iff (!rst_n)
    ($rose(flag) && $past(!mon_en, 2)) |-> $past(fail_evt))
    else $error("flag rose without event");

endmodule

// File: tb/lfcm_monitor_test.sv
`timescale 1ns/1ps
module lfcm_monitor_test;

  localparam int unsigned TMO = 64;

  logic        rc_clk = 1'b0;
  logic        mon_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mon_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fail_evt;
  logic        fail_irq;

  logic mon_run = 1'b0;
  int   checks = 0;
  int   failures = 0;
  int   evt_count = 0;
  int   back_to_back = 0;
  logic prev_evt = 1'b0;

  lfcm_monitor #(.TMO_CYC(TMO)) uut (
    .rc_clk    (rc_clk),
    .mon_clk   (mon_clk),
    .rst_n     (rst_n),
    .mon_en    (mon_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .fail_evt  (fail_evt),
    .fail_irq  (fail_irq)
  );

  always #2 rc_clk = ~rc_clk;

  // Monitored clock: 1 ns period when running, held low when stopped.
  always begin
    if (mon_run) begin
      #0.5 mon_clk = ~mon_clk;
    end else begin
      mon_clk = 1'b0;
      #1;
    end
  end

  always @(negedge rc_clk) begin
    if (rst_n) begin
      if (fail_evt) evt_count++;
      if (fail_evt && prev_evt) back_to_back++;
      prev_evt = fail_evt;
    end
  end

  task automatic check(input string req, input string what,
                       input longint actual, input longint expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic check_true(input string req, input string what, input bit cond,
                            input longint actual);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=condition true", req, what, actual);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge rc_clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge rc_clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge rc_clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_rc(input int n);
    repeat (n) @(negedge rc_clk);
  endtask

  task automatic clear_flag();
    write_reg(2'd2, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    read_reg(2'd0, v); check("R1", "divider after reset", v, 3);
    read_reg(2'd1, v); check("R1", "threshold after reset", v, 0);
    read_reg(2'd2, v); check("R1", "status after reset", v, 0);
    check("R1", "fail_evt after reset", fail_evt, 0);
    check("R1", "fail_irq after reset", fail_irq, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    write_reg(2'd0, 32'hFF);
    read_reg(2'd0, v); check("R9", "divider keeps 2 bits", v, 3);
    write_reg(2'd1, 32'h0001_FFFF);
    read_reg(2'd1, v); check("R10", "threshold keeps 12 bits", v, 32'hFFF);
    read_reg(2'd3, v); check("R10", "spare address reads zero", v, 0);
    write_reg(2'd1, 32'h0);
  endtask

  task automatic t_zero_threshold();
    mon_run = 1'b0; mon_en = 1'b1;
    evt_count = 0;
    wait_rc(4 * TMO);
    check("R4", "events with zero threshold and stopped clock", evt_count, 0);
    check("R4", "irq with zero threshold", fail_irq, 0);
  endtask

  task automatic t_fast_pass();
    mon_run = 1'b1;
    write_reg(2'd0, 32'd0);
    write_reg(2'd1, 32'd5);
    wait_rc(40);
    evt_count = 0;
    wait_rc(400);
    check("R3", "events when count above threshold", evt_count, 0);
    check("R3", "irq when count above threshold", fail_irq, 0);
  endtask

  task automatic t_low_fail();
    write_reg(2'd1, 32'd4000);
    evt_count = 0;
    wait_rc(200);
    check_true("R2", "events when count below threshold", evt_count > 0, evt_count);
    check("R2", "irq after low count", fail_irq, 1);
    check("R8", "back-to-back event cycles", back_to_back, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    write_reg(2'd1, 32'd5);
    wait_rc(40);
    write_reg(2'd2, 32'h0);
    read_reg(2'd2, v); check("R7", "writing zero keeps flag", v, 1);
    write_reg(2'd2, 32'h1);
    read_reg(2'd2, v); check("R7", "writing one clears flag", v, 0);
    check("R7", "irq follows cleared flag", fail_irq, 0);
  endtask

  task automatic t_disabled();
    mon_en = 1'b0;
    write_reg(2'd1, 32'd4000);
    evt_count = 0;
    wait_rc(300);
    check("R5", "events while disabled", evt_count, 0);
    check("R5", "irq while disabled", fail_irq, 0);
    write_reg(2'd1, 32'd5);
    wait_rc(40);
    mon_en = 1'b1;
  endtask

  task automatic t_divider();
    // 1 ns clock: divide-by-1 windows hold roughly 12..16 edges,
    // divide-by-8 windows roughly 40..44; 28 lies between.
    write_reg(2'd0, 32'd0);
    write_reg(2'd1, 32'd28);
    wait_rc(40);
    evt_count = 0;
    wait_rc(200);
    check_true("R9", "short window fails at threshold 28", evt_count > 0, evt_count);
    write_reg(2'd0, 32'd3);
    wait_rc(40);
    clear_flag();
    evt_count = 0;
    wait_rc(300);
    check("R9", "long window passes at threshold 28", evt_count, 0);
    check("R9", "irq with long window", fail_irq, 0);
  endtask

  task automatic t_stopped();
    write_reg(2'd0, 32'd0);
    write_reg(2'd1, 32'd100);
    wait_rc(20);
    clear_flag();
    mon_run = 1'b0;
    wait_rc(4);
    evt_count = 0;
    wait_rc(TMO + 30);
    check_true("R6", "stopped clock caught by timeout", evt_count > 0, evt_count);
    check("R6", "irq after timeout", fail_irq, 1);
    check("R8", "back-to-back event cycles overall", back_to_back, 0);
  endtask

  initial begin
    fork
      begin
        wait_rc(5);
        #1 rst_n = 1'b1;
        wait_rc(2);
        t_reset();
        t_regmap();
        t_zero_threshold();
        t_fast_pass();
        t_low_fail();
        t_w1c();
        t_disabled();
        t_divider();
        t_stopped();
      end
      begin
        repeat (150000) @(posedge rc_clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule